// File: doc/BRIEF.md
# Receive Frame Ring with Interrupt

This block holds received Ethernet frames in a small ring of fixed-size slots until the command side collects them. Frames enter as a byte stream with a per-byte valid and an end-of-frame marker. Each frame lands whole in one slot along with its recorded length. Bytes past the slot size are discarded and the length saturates at the slot size. Whether a frame is accepted is decided on its first byte: when every slot is occupied, the whole frame is thrown away and a one-cycle drop pulse marks its end.

Only a write index and an occupancy count are kept. The oldest entry is derived as (write index + slots - count) mod slots. A fetch request returns that oldest frame: an acknowledge carries its length, and the bytes follow on consecutive cycles. The count drops by one on the cycle that shows the last byte, so the slot being read cannot be reused while it is still being streamed. A flush empties the queue without moving the write index, and it also aborts any fetch that is still streaming.

The interrupt level rises on each accepted frame while interrupts are enabled. It falls when a fetch leaves the queue empty, including a fetch made on an already empty queue.

Top module: `frame_rx_ring`

## Requirements
- R1: After reset, queue_len is 0, irq is low, and fetch_ack, out_valid, out_last and rx_drop are all low.
- R2: An accepted frame whose last byte is sampled at clock edge E is stored with its length, and queue_len shows the count plus one after E.
- R3: A frame longer than SLOT_BYTES keeps only its first SLOT_BYTES bytes, and its recorded length is SLOT_BYTES.
- R4: A frame whose first byte arrives while queue_len equals SLOTS is discarded. rx_drop is high for exactly the one cycle after its last byte, and queue_len and the stored frames are unchanged.
- R5: A fetch_req sampled at edge E0 while the queue holds frames raises fetch_ack with fetch_len after E0. The oldest frame's bytes then appear on out_byte, with out_valid high, after edges E0+1 through E0+len, and out_last marks the final byte. Frames come out in arrival order.
- R6: A fetch_req on an empty queue raises fetch_ack with fetch_len 0, produces no out_valid, and drives irq low.
- R7: queue_len decreases by one on the same edge that presents the last byte of a fetched frame.
- R8: When irq_en is high at the edge that accepts a frame, irq is high after that edge. An accepted frame never raises irq while irq_en is low.
- R9: When a fetch ends with queue_len 0, irq is low from that edge on.
- R10: A flush sampled at an edge sets queue_len to 0, leaves irq as it was, and stops any fetch in progress: no out_valid follows. Frames received afterwards are fetched normally.
- R11: A frame received while a fetch is streaming is stored when a slot is free. It does not alter the bytes being fetched, and it is fetched next.
- R12: A fetch_req made while a fetch is streaming, or in a cycle with flush high, is ignored: no fetch_ack follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_byte | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_drop | output | 1 | One-cycle pulse: a frame was discarded because the ring was full |
| irq_en | input | 1 | Interrupt enable level |
| irq | output | 1 | Interrupt level |
| flush | input | 1 | Empty the queue and abort any fetch |
| fetch_req | input | 1 | Request the oldest frame |
| fetch_ack | output | 1 | One-cycle acknowledge of a request |
| fetch_len | output | 16 | Length of the fetched frame, 0 when the queue was empty |
| out_valid | output | 1 | Fetched byte valid |
| out_byte | output | 8 | Fetched byte |
| out_last | output | 1 | Marks the final fetched byte |
| queue_len | output | 16 | Number of queued frames |

## Verification
If the write index or the count is wrong, the derived oldest slot is wrong too. The very next fetch then returns another frame's length or bytes, or the frames come out of order, and a byte-by-byte comparison catches this on the ack cycle or on the first byte. If the count goes wrong at one edge, queue_len shows it right after that edge, so the bench samples queue_len after every receive, fetch, flush and drop. A wrong interrupt flip-flop is visible on irq one cycle after the accept or the emptying fetch that should have set or cleared it. The bench compares irq with the expected level after each of these operations.

// File: rtl/frx_pkg.sv
package frx_pkg;
   typedef enum logic [0:0] {
      FETCH_IDLE   = 1'b0,
      FETCH_STREAM = 1'b1
   } fetch_state_e;
endpackage

// File: rtl/frx_store.sv
module frx_store #(
   parameter int SLOTS      = 4,
   parameter int SLOT_BYTES = 512
) (
   input  logic                          clk,
   input  logic                          wr_en,
   input  logic [$clog2(SLOTS)-1:0]      wr_slot,
   input  logic [$clog2(SLOT_BYTES)-1:0] wr_off,
   input  logic [7:0]                    wr_byte,
   input  logic [$clog2(SLOTS)-1:0]      rd_slot,
   input  logic [$clog2(SLOT_BYTES)-1:0] rd_off,
   output logic [7:0]                    rd_byte
);
   localparam int DEPTH = SLOTS * SLOT_BYTES;
   localparam int AW    = $clog2(DEPTH);

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] waddr;
   logic [AW-1:0] raddr;

   assign waddr = AW'(wr_slot) * AW'(SLOT_BYTES) + AW'(wr_off);
   assign raddr = AW'(rd_slot) * AW'(SLOT_BYTES) + AW'(rd_off);

   always_ff @(posedge clk) begin
      if (wr_en) mem[waddr] <= wr_byte;
      rd_byte <= mem[raddr];
   end
endmodule

// File: rtl/frx_writer.sv
module frx_writer #(
   parameter int SLOTS      = 4,
   parameter int SLOT_BYTES = 512
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rx_valid,
   input  logic                            rx_last,
   input  logic [$clog2(SLOTS+1)-1:0]      count,
   output logic                            mem_we,
   output logic [$clog2(SLOT_BYTES)-1:0]   mem_off,
   output logic                            commit,
   output logic [$clog2(SLOT_BYTES+1)-1:0] commit_len,
   output logic                            drop
);
   localparam int OW = $clog2(SLOT_BYTES);
   localparam int LW = $clog2(SLOT_BYTES + 1);
   localparam int CW = $clog2(SLOTS + 1);

   logic          in_frame;
   logic          keep;
   logic [LW-1:0] pos;
   logic [LW-1:0] idx;
   logic [LW-1:0] nxt;
   logic          acc;

   // accept decision is taken on the first byte and held for the frame
   assign idx        = in_frame ? pos : '0;
   assign acc        = in_frame ? keep : (count < CW'(SLOTS));
   assign mem_we     = rx_valid && acc && (idx < LW'(SLOT_BYTES));
   assign mem_off    = idx[OW-1:0];
   assign nxt        = (idx == LW'(SLOT_BYTES)) ? idx : idx + 1'b1;
   assign commit     = rx_valid && rx_last && acc;
   assign commit_len = nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         keep     <= 1'b0;
         pos      <= '0;
         drop     <= 1'b0;
      end else begin
         drop <= rx_valid && rx_last && !acc;
         if (rx_valid) begin
            if (rx_last) begin
               in_frame <= 1'b0;
            end else begin
               in_frame <= 1'b1;
               keep     <= acc;
               pos      <= nxt;
            end
         end
      end
   end

   // R3: a recorded length never exceeds the slot and never is zero
   assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (commit_len <= LW'(SLOT_BYTES)) && (commit_len != '0));
endmodule

// File: rtl/frx_reader.sv
module frx_reader
   import frx_pkg::*;
#(
   parameter int SLOTS      = 4,
   parameter int SLOT_BYTES = 512
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            flush,
   input  logic                            fetch_req,
   input  logic [$clog2(SLOTS+1)-1:0]      count,
   input  logic [$clog2(SLOTS)-1:0]        wr_idx,
   input  logic [$clog2(SLOT_BYTES+1)-1:0] head_len,
   output logic [$clog2(SLOTS)-1:0]        head,
   output logic [$clog2(SLOTS)-1:0]        rd_slot,
   output logic [$clog2(SLOT_BYTES)-1:0]   rd_off,
   output logic                            fetch_ack,
   output logic [15:0]                     fetch_len,
   output logic                            out_valid,
   output logic                            out_last,
   output logic                            finish,
   output logic                            empty_fetch
);
   localparam int IW = $clog2(SLOTS);
   localparam int OW = $clog2(SLOT_BYTES);
   localparam int LW = $clog2(SLOT_BYTES + 1);

   fetch_state_e  st;
   logic [IW-1:0] slot_q;
   logic [LW-1:0] ptr;
   logic [LW-1:0] lenq;
   logic [IW+1:0] diff;
   logic          start;

   // oldest entry = (write index + SLOTS - count) mod SLOTS
   assign diff = {2'b00, wr_idx} + (IW+2)'(SLOTS) - (IW+2)'(count);
   always_comb begin
      if (diff >= (IW+2)'(SLOTS)) head = IW'(diff - (IW+2)'(SLOTS));
      else                        head = IW'(diff);
   end

   assign start       = fetch_req && (st == FETCH_IDLE) && !flush;
   assign empty_fetch = start && (count == '0);
   assign finish      = (st == FETCH_STREAM) && (ptr == lenq - 1'b1) && !flush;
   assign rd_slot     = slot_q;
   assign rd_off      = ptr[OW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= FETCH_IDLE;
         slot_q    <= '0;
         ptr       <= '0;
         lenq      <= '0;
         fetch_ack <= 1'b0;
         fetch_len <= '0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
      end else begin
         fetch_ack <= start;
         out_valid <= (st == FETCH_STREAM) && !flush;
         out_last  <= finish;
         if (start) begin
            fetch_len <= (count == '0) ? 16'd0 : 16'(head_len);
            st        <= (count == '0) ? FETCH_IDLE : FETCH_STREAM;
            slot_q    <= head;
            ptr       <= '0;
            lenq      <= head_len;
         end else if (st == FETCH_STREAM) begin
            if (flush || finish) st <= FETCH_IDLE;
            else                 ptr <= ptr + 1'b1;
         end
      end
   end

   // R5: an accepted request is acknowledged on the next cycle
   assert_ack_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> fetch_ack);
   // R5: bytes of a frame arrive on consecutive cycles
   assert_stream_gapless_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last && !flush) |=> out_valid);
   // R6: empty queue gives a zero-length acknowledge and no data
   assert_empty_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      empty_fetch |=> (fetch_ack && fetch_len == 16'd0 && !out_valid));
   // R12: requests during a stream are not acknowledged
   assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && st == FETCH_STREAM) |=> !fetch_ack);
endmodule

// File: rtl/frame_rx_ring.sv
module frame_rx_ring #(
   parameter int SLOTS      = 4,
   parameter int SLOT_BYTES = 512
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_valid,
   input  logic [7:0]  rx_byte,
   input  logic        rx_last,
   output logic        rx_drop,
   input  logic        irq_en,
   output logic        irq,
   input  logic        flush,
   input  logic        fetch_req,
   output logic        fetch_ack,
   output logic [15:0] fetch_len,
   output logic        out_valid,
   output logic [7:0]  out_byte,
   output logic        out_last,
   output logic [15:0] queue_len
);
   localparam int IW = $clog2(SLOTS);
   localparam int OW = $clog2(SLOT_BYTES);
   localparam int LW = $clog2(SLOT_BYTES + 1);
   localparam int CW = $clog2(SLOTS + 1);

   generate
      if (SLOTS < 2 || SLOTS > 256) begin : g_bad_slots
         $error("frame_rx_ring: SLOTS must lie in 2..256");
      end
      if (SLOT_BYTES < 2 || SLOT_BYTES > 65535) begin : g_bad_bytes
         $error("frame_rx_ring: SLOT_BYTES must lie in 2..65535");
      end
   endgenerate

   logic [IW-1:0]       wr_idx;
   logic [CW-1:0]       count;
   logic [CW-1:0]       cnt_n;
   logic                mem_we;
   logic [OW-1:0]       mem_off;
   logic                commit;
   logic [LW-1:0]       commit_len;
   logic [IW-1:0]       head;
   logic [IW-1:0]       rd_slot;
   logic [OW-1:0]       rd_off;
   logic                finish;
   logic                empty_fetch;
   logic [SLOTS*LW-1:0] lens_flat;
   logic [LW-1:0]       head_len;

   frx_writer #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_wr (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_last(rx_last),
      .count(count), .mem_we(mem_we), .mem_off(mem_off), .commit(commit),
      .commit_len(commit_len), .drop(rx_drop));

   frx_store #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_mem (
      .clk(clk), .wr_en(mem_we), .wr_slot(wr_idx), .wr_off(mem_off),
      .wr_byte(rx_byte), .rd_slot(rd_slot), .rd_off(rd_off), .rd_byte(out_byte));

   frx_reader #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_rd (
      .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_req(fetch_req),
      .count(count), .wr_idx(wr_idx), .head_len(head_len), .head(head),
      .rd_slot(rd_slot), .rd_off(rd_off), .fetch_ack(fetch_ack),
      .fetch_len(fetch_len), .out_valid(out_valid), .out_last(out_last),
      .finish(finish), .empty_fetch(empty_fetch));

   // per-slot length records
   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_len
         logic [LW-1:0] len_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                             len_q <= '0;
            else if (commit && wr_idx == IW'(s))    len_q <= commit_len;
         end
         assign lens_flat[s*LW +: LW] = len_q;
      end
   endgenerate

   assign head_len  = lens_flat[head*LW +: LW];
   assign queue_len = 16'(count);

   always_comb begin
      cnt_n = count;
      if (commit) cnt_n = cnt_n + 1'b1;
      if (finish) cnt_n = cnt_n - 1'b1;
      if (flush)  cnt_n = commit ? CW'(1) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_idx <= '0;
         count  <= '0;
         irq    <= 1'b0;
      end else begin
         count <= cnt_n;
         if (commit) wr_idx <= (wr_idx == IW'(SLOTS - 1)) ? '0 : wr_idx + 1'b1;
         if (commit && irq_en)                          irq <= 1'b1;
         else if ((finish && cnt_n == '0) || empty_fetch) irq <= 1'b0;
      end
   end

   // R4: occupancy never exceeds the number of slots
   assert_count_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
      queue_len <= 16'(SLOTS));
   // R4: a discarded frame does not move the write index
   assert_drop_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_drop |-> $stable(wr_idx));
   // R8: the interrupt only rises while enabled
   assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(irq_en));
   // R9: a fetch that empties the queue leaves irq low
   assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && count == CW'(1) && !commit) |=> !irq);
endmodule

// File: tb/frame_rx_ring_test.sv
`timescale 1ns/1ps
module frame_rx_ring_test;
   localparam int N  = 4;
   localparam int SB = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_last = 1'b0, irq_en = 1'b0;
   logic        flush = 1'b0, fetch_req = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        rx_drop, irq, fetch_ack, out_valid, out_last;
   logic [7:0]  out_byte;
   logic [15:0] fetch_len, queue_len;

   int total = 0;
   int bad   = 0;
   int m_cnt = 0;
   int m_head = 0;
   int m_tag [N];
   int m_len [N];
   bit m_irq = 1'b0;

   always #2 clk = ~clk;

   frame_rx_ring #(.SLOTS(N), .SLOT_BYTES(SB)) uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_last(rx_last), .rx_drop(rx_drop), .irq_en(irq_en), .irq(irq),
      .flush(flush), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
      .fetch_len(fetch_len), .out_valid(out_valid), .out_byte(out_byte),
      .out_last(out_last), .queue_len(queue_len));

   function automatic logic [7:0] pat(int tag, int i);
      return 8'((tag * 29 + i * 7 + (i >> 8)) & 255);
   endfunction

   function automatic int clip(int len);
      return (len > SB) ? SB : len;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(int len, int tag, string req);
      bit acc;
      acc = (m_cnt < N);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_byte  = pat(tag, i);
         rx_last  = (i == len - 1);
      end
      @(posedge clk); #1;
      rx_valid = 1'b0; rx_last = 1'b0;
      if (acc) begin
         m_tag[(m_head + m_cnt) % N] = tag;
         m_len[(m_head + m_cnt) % N] = clip(len);
         m_cnt++;
         if (irq_en) m_irq = 1'b1;
      end
      chk(queue_len == 16'(m_cnt), {req, " R2 queue_len"}, queue_len, m_cnt);
      chk(rx_drop == !acc, {req, " R4 rx_drop"}, rx_drop, !acc);
      chk(irq == m_irq, {req, " R8 irq"}, irq, m_irq);
   endtask

   task automatic fetch_chk(string req);
      int elen, etag;
      elen = (m_cnt == 0) ? 0 : m_len[m_head];
      etag = (m_cnt == 0) ? 0 : m_tag[m_head];
      @(negedge clk); fetch_req = 1'b1;
      @(posedge clk); #1; fetch_req = 1'b0;
      chk(fetch_ack == 1'b1, {req, " R5 fetch_ack"}, fetch_ack, 1);
      chk(fetch_len == 16'(elen), {req, " R5 fetch_len"}, fetch_len, elen);
      if (elen == 0) begin
         m_irq = 1'b0;
         chk(irq == 1'b0, {req, " R6 irq"}, irq, 0);
         @(posedge clk); #1;
         chk(out_valid == 1'b0, {req, " R6 out_valid"}, out_valid, 0);
      end else begin
         for (int i = 0; i < elen; i++) begin
            @(posedge clk); #1;
            chk(out_valid && out_byte == pat(etag, i) && out_last == (i == elen - 1),
                {req, " R5 byte"}, out_byte, pat(etag, i));
         end
         m_head = (m_head + 1) % N;
         m_cnt--;
         if (m_cnt == 0) m_irq = 1'b0;
         chk(queue_len == 16'(m_cnt), {req, " R7 queue_len"}, queue_len, m_cnt);
         chk(irq == m_irq, {req, " R9 irq"}, irq, m_irq);
         @(posedge clk); #1;
         chk(out_valid == 1'b0, {req, " R5 stream end"}, out_valid, 0);
      end
   endtask

   task automatic do_flush(string req);
      @(negedge clk); flush = 1'b1;
      @(posedge clk); #1; flush = 1'b0;
      m_cnt = 0;
      chk(queue_len == 16'd0, {req, " R10 queue_len"}, queue_len, 0);
      chk(irq == m_irq, {req, " R10 irq kept"}, irq, m_irq);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      chk(queue_len == 0 && irq == 0, "R1 queue/irq", queue_len, 0);
      chk(!fetch_ack && !out_valid && !out_last && !rx_drop, "R1 outputs", out_valid, 0);

      fetch_chk("R6 empty");

      irq_en = 1'b1;
      send(10, 1, "R2 a"); send(3, 2, "R2 b"); send(1, 3, "R2 c");
      fetch_chk("R5 order1"); fetch_chk("R5 order2"); fetch_chk("R9 last");

      send(5, 11, "R4 f1"); send(6, 12, "R4 f2"); send(7, 13, "R4 f3"); send(8, 14, "R4 f4");
      send(9, 15, "R4 full");
      chk(queue_len == 16'(N), "R4 count held", queue_len, N);
      for (int i = 0; i < N; i++) fetch_chk("R4 drain");

      send(530, 21, "R3 long"); fetch_chk("R3 trunc");
      send(SB, 22, "R3 exact"); fetch_chk("R3 exact");

      irq_en = 1'b0;
      send(4, 31, "R8 masked");
      chk(irq == 1'b0, "R8 irq masked", irq, 0);
      fetch_chk("R8 masked fetch");

      irq_en = 1'b1;
      send(12, 41, "R10 a"); send(12, 42, "R10 b");
      do_flush("R10 flush");
      send(6, 43, "R10 after"); fetch_chk("R10 after");

      // R11: frame arrives while a fetch is streaming
      send(100, 51, "R11 first");
      fork
         fetch_chk("R11 fetch");
         begin
            repeat (5) @(posedge clk);
            send(20, 52, "R11 concurrent");
         end
      join
      fetch_chk("R11 next");

      // R12: second request during a stream
      send(12, 61, "R12 frame");
      fork
         fetch_chk("R12 fetch");
         begin
            repeat (4) @(posedge clk);
            @(negedge clk); fetch_req = 1'b1;
            @(posedge clk); #1; fetch_req = 1'b0;
            @(posedge clk); #1;
            chk(fetch_ack == 1'b0, "R12 no ack", fetch_ack, 0);
         end
      join

      // R10: flush aborts a running fetch
      send(50, 71, "R10 abort frame");
      @(negedge clk); fetch_req = 1'b1;
      @(posedge clk); #1; fetch_req = 1'b0;
      repeat (5) @(posedge clk);
      do_flush("R10 abort");
      @(posedge clk); #1;
      chk(out_valid == 1'b0, "R10 abort out_valid", out_valid, 0);
      fetch_chk("R10 empty after abort");

      // constrained random mix
      for (int k = 0; k < 160; k++) begin
         int op;
         int len;
         op = int'($urandom % 10);
         if (op <= 3 || op == 9) begin
            len = ($urandom % 8 == 0) ? 500 + int'($urandom % 40) : 1 + int'($urandom % 60);
            send(len, 100 + k, "R2 rnd send");
         end else if (op <= 6) begin
            fetch_chk("R5 rnd fetch");
         end else if (op == 7) begin
            do_flush("R10 rnd flush");
         end else begin
            @(negedge clk); irq_en = ~irq_en;
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule